// File: doc/BRIEF.md
# Saturating Hit/Miss Event Monitor

This block keeps two performance tallies for a cache pipeline: one counts lookup hits, the other counts lookup misses. The pipeline delivers a one-cycle pulse per event on a dedicated input for each kind. Software steers the block through a small control register written over a simple write port. The register holds one run bit and one clear bit per counter, so either tally can be started, frozen or zeroed without touching the other. Both tallies are always visible on output ports for readback.

Each counter stops at its all-ones value instead of rolling over, so a long profiling run never reports a small, misleading number. Freezing a counter keeps whatever it has accumulated. A clear bit holds its counter at zero for as long as it stays set; software sets it and then drops it to restart from zero.

Top module: `hitmiss_monitor`

## Requirements
- R1: After rst_n has been low, both hit_count and miss_count read zero.
- R2: Control bit 0 runs the hit counter, bit 1 runs the miss counter, bit 2 clears the hit counter and bit 3 clears the miss counter (each clear bit sits two places above the matching run bit). A value written with ctrl_we takes effect from the cycle after the write edge; an event sampled on the same edge as the write is judged by the previous settings.
- R3: A hit_evt pulse sampled while the hit counter runs raises hit_count by exactly one, visible after that clock edge.
- R4: A miss_evt pulse sampled while the miss counter runs raises miss_count by exactly one, visible after that clock edge.
- R5: While a counter's run bit is zero, its value stays unchanged whatever events arrive.
- R6: A counter that has reached 2^CNT_W-1 (CNT_W defaults to 32) stays there on further events and never wraps.
- R7: While a counter's clear bit is set it reads zero and ignores events; after the bit is dropped, counting resumes from zero.
- R8: Hit and miss pulses in the same cycle both count in that cycle, and clearing or freezing one counter leaves the other's behaviour unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hit_evt | input | 1 | One pulse per cache hit |
| miss_evt | input | 1 | One pulse per cache miss |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control value: run bits [1:0], clear bits [3:2] |
| hit_count | output | CNT_W | Hit tally |
| miss_count | output | CNT_W | Miss tally |

## Verification
Two pairs of functions can coincide in one cycle: a hit and a miss pulse arriving together, and a control write landing on the same edge as an event. The bench drives both pulses for several consecutive cycles with both counters running and expects each tally to grow by the cycle count, then repeats with only one side cleared so the other must keep counting. For the write collision it raises the run bit and a hit pulse on the same edge and expects the tally to stay put until the following cycle.

// File: rtl/hitmiss_monitor_pkg.sv
package hitmiss_monitor_pkg;
  localparam int NUM_EVT = 2;
  localparam int CTRL_W  = 2 * NUM_EVT;
  localparam int EVT_HIT  = 0;
  localparam int EVT_MISS = 1;

  function automatic int run_pos(input int idx);
    return idx;
  endfunction

  function automatic int clr_pos(input int idx);
    return idx + NUM_EVT;
  endfunction
endpackage

// File: rtl/hitmiss_rst_sync.sv
module hitmiss_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/hitmiss_ctrl_reg.sv
module hitmiss_ctrl_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] ctrl_q
);
  logic [WIDTH-1:0] ctrl_d;
  logic             ctrl_ce;

  always_comb begin
    ctrl_ce = wr_en;
    ctrl_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ce) ctrl_q <= ctrl_d;
  end

  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl_q == $past(wr_data));

  assert_ctrl_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/hitmiss_sat_counter.sv
module hitmiss_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             run,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_max;
  logic             bump;
  logic             cnt_ce;

  always_comb begin
    at_max = (cnt_q == CNT_MAX);
    bump   = run && evt && !at_max;
    cnt_ce = clr || bump;
    cnt_d  = cnt_q;
    if (clr)       cnt_d = '0;
    else if (bump) cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !clr) |=> count == CNT_MAX);

  assert_frozen_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(count));

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && evt && !clr && count != CNT_MAX) |=> count == $past(count) + {{(CNT_W-1){1'b0}}, 1'b1});

  assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !clr) |=> $stable(count));
endmodule

// File: rtl/hitmiss_monitor.sv
module hitmiss_monitor
  import hitmiss_monitor_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_evt,
  input  logic             miss_evt,
  input  logic             ctrl_we,
  input  logic [3:0]       ctrl_wdata,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  logic                            srst_n;
  logic [CTRL_W-1:0]               ctrl_q;
  logic [NUM_EVT-1:0]              evt_vec;
  logic [NUM_EVT-1:0][CNT_W-1:0]   cnt_vec;

  hitmiss_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (srst_n)
  );

  hitmiss_ctrl_reg #(.WIDTH(CTRL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (ctrl_we),
    .wr_data (ctrl_wdata),
    .ctrl_q  (ctrl_q)
  );

  always_comb begin
    evt_vec           = '0;
    evt_vec[EVT_HIT]  = hit_evt;
    evt_vec[EVT_MISS] = miss_evt;
  end

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_cnt
    hitmiss_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (srst_n),
      .evt   (evt_vec[g]),
      .run   (ctrl_q[run_pos(g)]),
      .clr   (ctrl_q[clr_pos(g)]),
      .count (cnt_vec[g])
    );
  end

  assign hit_count  = cnt_vec[EVT_HIT];
  assign miss_count = cnt_vec[EVT_MISS];

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(srst_n) |-> (hit_count == '0 && miss_count == '0));

  assert_pair_count_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (hit_evt && miss_evt && ctrl_q == 4'b0011 && hit_count != {CNT_W{1'b1}} && miss_count != {CNT_W{1'b1}})
    |=> (hit_count != $past(hit_count) && miss_count != $past(miss_count)));
endmodule

// File: tb/hitmiss_monitor_bench.sv
module hitmiss_monitor_bench;
  localparam int W = 4;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hit_evt = 1'b0;
  logic miss_evt = 1'b0;
  logic ctrl_we = 1'b0;
  logic [3:0] ctrl_wdata = 4'h0;
  logic [W-1:0] hit_count;
  logic [W-1:0] miss_count;

  int n_checks = 0;
  int n_fail = 0;
  logic [3:0] m_ctrl = 4'h0;
  int exp_hit = 0;
  int exp_miss = 0;

  always #10 clk = ~clk;

  hitmiss_monitor #(.CNT_W(W)) u_hitmiss_monitor (
    .clk(clk), .rst_n(rst_n), .hit_evt(hit_evt), .miss_evt(miss_evt),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench model of one sampled edge, built from the requirements
  task automatic model_edge(input logic h, input logic m);
    if (m_ctrl[2]) exp_hit = 0;
    else if (m_ctrl[0] && h && exp_hit < int'(TOP)) exp_hit++;
    if (m_ctrl[3]) exp_miss = 0;
    else if (m_ctrl[1] && m && exp_miss < int'(TOP)) exp_miss++;
  endtask

  task automatic wr(input logic [3:0] v);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    model_edge(1'b0, 1'b0);
    m_ctrl = v;
    ctrl_we = 1'b0;
  endtask

  task automatic drive(input logic h, input logic m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hit_evt = h; miss_evt = m;
      @(negedge clk);
      model_edge(h, m);
      hit_evt = 1'b0; miss_evt = 1'b0;
    end
  endtask

  task automatic check_both(input string req);
    check(req, int'(hit_count), exp_hit);
    check(req, int'(miss_count), exp_miss);
  endtask

  task automatic t_reset;
    check("R1 hit", int'(hit_count), 0);
    check("R1 miss", int'(miss_count), 0);
  endtask

  task automatic t_idle_disabled;
    drive(1'b1, 1'b1, 3);
    check("R5 disabled hit", int'(hit_count), 0);
    check("R5 disabled miss", int'(miss_count), 0);
  endtask

  task automatic t_hit_only;
    wr(4'b0001);
    drive(1'b1, 1'b1, 3);
    check("R3 hit", int'(hit_count), 3);
    check("R2 miss not run", int'(miss_count), 0);
  endtask

  task automatic t_miss_only;
    wr(4'b0010);
    drive(1'b1, 1'b1, 2);
    check("R4 miss", int'(miss_count), 2);
    check("R5 hit frozen", int'(hit_count), 3);
  endtask

  task automatic t_both;
    wr(4'b0011);
    drive(1'b1, 1'b1, 4);
    check("R8 hit pair", int'(hit_count), 7);
    check("R8 miss pair", int'(miss_count), 6);
    drive(1'b1, 1'b0, 1);
    check_both("R3 hit alone");
  endtask

  task automatic t_stop;
    wr(4'b0000);
    drive(1'b1, 1'b1, 5);
    check("R5 stop hit", int'(hit_count), 8);
    check("R5 stop miss", int'(miss_count), 6);
  endtask

  task automatic t_clear_one;
    wr(4'b0111);
    drive(1'b1, 1'b1, 3);
    check("R7 held zero", int'(hit_count), 0);
    check("R8 miss runs beside clear", int'(miss_count), 9);
    wr(4'b0011);
    drive(1'b1, 1'b1, 2);
    check("R7 resume", int'(hit_count), 2);
    check("R8 miss", int'(miss_count), 11);
  endtask

  task automatic t_saturate;
    drive(1'b1, 1'b1, 20);
    check("R6 hit top", int'(hit_count), int'(TOP));
    check("R6 miss top", int'(miss_count), int'(TOP));
    drive(1'b1, 1'b1, 3);
    check_both("R6 stays");
  endtask

  task automatic t_write_collision;
    wr(4'b1100);
    wr(4'b0000);
    check_both("R7 cleared");
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = 4'b0001; hit_evt = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0; hit_evt = 1'b0;
    check("R2 same-edge event ignored", int'(hit_count), 0);
    m_ctrl = 4'b0001;
    drive(1'b1, 1'b0, 1);
    check("R2 next cycle counts", int'(hit_count), 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_idle_disabled();
    t_hit_only();
    t_miss_only();
    t_both();
    t_stop();
    t_clear_one();
    t_saturate();
    t_write_collision();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule